// File: doc/BRIEF.md
# Decrementer Tick Prescaler

This block derives a clock-enable pulse from the system clock and uses it to step a 32-bit down-counter. The pulse rate is the system clock divided by a power of two. The divide ratio is picked from one of two fields of a clock-control word. A mode bit in a PLL-control word chooses which field applies. The block produces enable pulses only. It does not gate or switch any clock.

Three configuration words (clock control, PLL control, timebase control) are written through one write port. Every write ORs the data into the stored word. A new ratio is applied only when a timebase-control write leaves its enable bit set, and that same write starts the prescaler. The down-counter can be loaded through the same port. A sticky flag records when the counter wraps below zero.

Top module: `dectick_top`

## Requirements
- R1: After reset the three configuration words, the counter value and the wrap flag read zero, `tick` is low and `div_sel` is 0 (divide by 1).
- R2: A write with `wr_addr` 0 (clock control), 1 (PLL control) or 2 (timebase control) ORs `wr_data` into that word. The result is visible on `clk_ctl`, `pll_ctl` or `tb_ctl` after the write edge.
- R3: The ratio is reloaded and the prescaler started only by a timebase-control write whose ORed result has bit 16 set. Other writes leave `div_sel` unchanged, and no tick occurs before such a write.
- R4: With PLL-control bit 10 set, clock-control bits [1:0] select the ratio. Code c gives divide by 2^(c+1), so `div_sel` = c+1.
- R5: With PLL-control bit 10 clear, clock-control bits [5:3] select the ratio. Code c from 0 to 6 gives divide by 2^c, so `div_sel` = c.
- R6: Code 7 in clock-control bits [5:3] (with bit 10 clear) is reserved. A reload that uses it keeps the previous ratio.
- R7: While running at ratio N > 1, `tick` is a one-cycle pulse every N clocks. At ratio 1 it is high on every cycle.
- R8: Every reload clears the prescale count. The first tick after the reload appears N clock edges after the write edge.
- R9: In the cycle `tick` is high, the counter value shows one less than before. Otherwise it holds.
- R10: A decrement from 0 gives 0xFFFFFFFF and sets `dec_wrap`. The flag stays set until the counter is loaded.
- R11: A write with `wr_addr` 3 loads `wr_data` into the counter and clears `dec_wrap`. This takes precedence over a decrement on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write target: 0 clock ctl, 1 PLL ctl, 2 timebase ctl, 3 counter load |
| wr_data | input | 32 | Write data |
| clk_ctl | output | 32 | Clock-control word |
| pll_ctl | output | 32 | PLL-control word |
| tb_ctl | output | 32 | Timebase-control word |
| div_sel | output | 3 | Active ratio as log2 of the divisor |
| tick | output | 1 | Decrement enable pulse |
| dec_value | output | 32 | Down-counter value |
| dec_wrap | output | 1 | Sticky wrap-below-zero flag |

## Verification
The cycle-by-cycle checks cover several rules. The OR-merge of clock-control writes is checked. So are the one-step decrement aligned with `tick`, the hold of the counter between ticks, the load precedence and the stickiness of the wrap flag. Two more cycle checks are that nothing ticks before start and that the ratio moves only on a reload. The mapping from field codes to ratios is exercised only by the bench scenarios, including the reserved code. The same holds for the exact delay to the first tick and the period between ticks.

// File: rtl/dectick_pkg.sv
package dectick_pkg;
  localparam int REG_W        = 32;
  localparam int SHIFT_W      = 3;
  localparam int MAX_SHIFT    = 6;
  localparam int TB_EN_BIT    = 16;
  localparam int PLL_MODE_BIT = 10;
  localparam int FINE_LSB     = 0;
  localparam int FINE_W       = 2;
  localparam int COARSE_LSB   = 3;
  localparam int COARSE_W     = 3;
  localparam logic [COARSE_W-1:0] COARSE_RSVD = '1;

  typedef enum logic [1:0] {
    SEL_CLKCTL = 2'd0,
    SEL_PLLCTL = 2'd1,
    SEL_TBCTL  = 2'd2,
    SEL_DECLD  = 2'd3
  } wsel_e;
endpackage

// File: rtl/dectick_cfg.sv
module dectick_cfg
  import dectick_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int SW = SHIFT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] clk_ctl_q,
  output logic [DW-1:0] pll_ctl_q,
  output logic [DW-1:0] tb_ctl_q,
  output logic [SW-1:0] shift_q,
  output logic          run_q,
  output logic          restart
);
  logic [DW-1:0]       tb_next;
  logic [SW-1:0]       dec_shift;
  logic                dec_ok;
  logic [FINE_W-1:0]   fine_code;
  logic [COARSE_W-1:0] coarse_code;

  assign tb_next     = tb_ctl_q | wr_data;
  assign restart     = wr_en && (wr_addr == SEL_TBCTL) && tb_next[TB_EN_BIT];
  assign fine_code   = clk_ctl_q[FINE_LSB +: FINE_W];
  assign coarse_code = clk_ctl_q[COARSE_LSB +: COARSE_W];

  always_comb begin
    dec_ok    = 1'b1;
    dec_shift = '0;
    if (pll_ctl_q[PLL_MODE_BIT]) begin
      dec_shift = SW'(fine_code) + SW'(1);
    end else begin
      dec_shift = SW'(coarse_code);
      if (coarse_code == COARSE_RSVD) dec_ok = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_ctl_q <= '0;
      pll_ctl_q <= '0;
      tb_ctl_q  <= '0;
      shift_q   <= '0;
      run_q     <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          SEL_CLKCTL: clk_ctl_q <= clk_ctl_q | wr_data;
          SEL_PLLCTL: pll_ctl_q <= pll_ctl_q | wr_data;
          SEL_TBCTL:  tb_ctl_q  <= tb_next;
          default: ;
        endcase
      end
      if (restart) begin
        run_q <= 1'b1;
        if (dec_ok) shift_q <= dec_shift;
      end
    end
  end
endmodule

// File: rtl/dectick_prescaler.sv
module dectick_prescaler
  import dectick_pkg::*;
#(
  parameter int SW    = SHIFT_W,
  parameter int CNT_W = MAX_SHIFT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic [SW-1:0] shift,
  output logic          tick_nxt,
  output logic          tick_q
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit    = (CNT_W'(1) << shift) - CNT_W'(1);
  assign tick_nxt = run && !restart && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q == limit) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      tick_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dectick_counter.sv
module dectick_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] value_q,
  output logic          wrap_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= '0;
      wrap_q  <= 1'b0;
    end else if (load) begin
      value_q <= load_val;
      wrap_q  <= 1'b0;
    end else if (step) begin
      value_q <= value_q - CW'(1);
      if (value_q == '0) wrap_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dectick_top.sv
module dectick_top
  import dectick_pkg::*;
#(
  parameter int DW    = REG_W,
  parameter int SW    = SHIFT_W,
  parameter int CNT_W = MAX_SHIFT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] clk_ctl,
  output logic [DW-1:0] pll_ctl,
  output logic [DW-1:0] tb_ctl,
  output logic [SW-1:0] div_sel,
  output logic          tick,
  output logic [DW-1:0] dec_value,
  output logic          dec_wrap
);
  logic run;
  logic restart;
  logic tick_nxt;
  logic load;

  assign load = wr_en && (wr_addr == SEL_DECLD);

  dectick_cfg #(.DW(DW), .SW(SW)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_ctl_q(clk_ctl), .pll_ctl_q(pll_ctl), .tb_ctl_q(tb_ctl),
    .shift_q(div_sel), .run_q(run), .restart(restart)
  );

  dectick_prescaler #(.SW(SW), .CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst(rst), .run(run), .restart(restart), .shift(div_sel),
    .tick_nxt(tick_nxt), .tick_q(tick)
  );

  dectick_counter #(.CW(DW)) u_dec (
    .clk(clk), .rst(rst), .step(tick_nxt), .load(load), .load_val(wr_data),
    .value_q(dec_value), .wrap_q(dec_wrap)
  );
endmodule

// File: rtl/dectick_checker.sv
module dectick_checker #(
  parameter int DW = 32,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] clk_ctl,
  input logic [SW-1:0] div_sel,
  input logic          tick,
  input logic [DW-1:0] dec_value,
  input logic          dec_wrap,
  input logic          run,
  input logic          restart
);
  logic ld;
  assign ld = wr_en && (wr_addr == 2'd3);

  assert_or_write_R2: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && wr_addr == 2'd0) |-> clk_ctl == ($past(clk_ctl) | $past(wr_data)));

  assert_ratio_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(restart) |-> $stable(div_sel));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick);

  assert_dec_step_R9: assert property (@(posedge clk) disable iff (rst)
    (tick && !$past(ld)) |-> dec_value == $past(dec_value) - DW'(1));

  assert_dec_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!tick && !$past(ld)) |-> $stable(dec_value));

  assert_wrap_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(dec_wrap) && !$past(ld)) |-> dec_wrap);

  assert_load_R11: assert property (@(posedge clk) disable iff (rst)
    $past(ld) |-> (dec_value == $past(wr_data) && !dec_wrap));
endmodule

bind dectick_top dectick_checker #(.DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .clk_ctl(clk_ctl), .div_sel(div_sel), .tick(tick), .dec_value(dec_value),
  .dec_wrap(dec_wrap), .run(run), .restart(restart)
);

// File: tb/test_dectick_top.sv
`timescale 1ns/1ps
module test_dectick_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] clk_ctl, pll_ctl, tb_ctl, dec_value;
  logic [2:0]  div_sel;
  logic        tick, dec_wrap;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dectick_top i_dectick_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_ctl(clk_ctl), .pll_ctl(pll_ctl), .tb_ctl(tb_ctl), .div_sel(div_sel),
    .tick(tick), .dec_value(dec_value), .dec_wrap(dec_wrap)
  );

  // {clock-ctl[7:0], pll bit 10, expected div_sel}
  localparam logic [11:0] VEC [12] = '{
    {8'h00, 1'b0, 3'd0}, {8'h08, 1'b0, 3'd1}, {8'h10, 1'b0, 3'd2},
    {8'h18, 1'b0, 3'd3}, {8'h20, 1'b0, 3'd4}, {8'h28, 1'b0, 3'd5},
    {8'h30, 1'b0, 3'd6}, {8'h38, 1'b0, 3'd0}, {8'h00, 1'b1, 3'd1},
    {8'h01, 1'b1, 3'd2}, {8'h02, 1'b1, 3'd3}, {8'h03, 1'b1, 3'd4}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    for (int k = 1; k <= 200; k++) begin
      @(negedge clk);
      if (tick) begin n = k; break; end
    end
  endtask

  initial begin
    int n, seen;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(tick == 1'b0, "R1 tick", 32'(tick), 0);
    chk(dec_value == 0 && dec_wrap == 1'b0, "R1 counter", dec_value, 0);
    chk(clk_ctl == 0 && pll_ctl == 0 && tb_ctl == 0, "R1 cfg", clk_ctl | pll_ctl | tb_ctl, 0);
    chk(div_sel == 3'd0, "R1 div_sel", 32'(div_sel), 0);

    // R2 OR-merge writes
    wr(2'd0, 32'h01);
    wr(2'd0, 32'h10);
    chk(clk_ctl == 32'h11, "R2 clk_ctl", clk_ctl, 32'h11);
    wr(2'd1, 32'h400);
    chk(pll_ctl == 32'h400, "R2 pll_ctl", pll_ctl, 32'h400);
    wr(2'd2, 32'h1);
    chk(tb_ctl == 32'h1, "R2 tb_ctl", tb_ctl, 32'h1);

    // R3 no start without bit 16
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tick) seen++;
    end
    chk(seen == 0, "R3 ticks before start", seen, 0);
    chk(div_sel == 3'd0, "R3 div_sel before start", 32'(div_sel), 0);
    wr(2'd2, 32'h10000);
    chk(tb_ctl == 32'h10001, "R2 tb_ctl merge", tb_ctl, 32'h10001);
    chk(div_sel == 3'd2, "R4 fine code 1", 32'(div_sel), 2);

    // Table: ratio decode (R4 R5 R6), first tick delay (R8), period (R7), wrap (R10)
    for (int i = 0; i < 12; i++) begin
      logic [2:0] es;
      es = VEC[i][2:0];
      do_reset();
      wr(2'd0, {24'h0, VEC[i][11:4]});
      wr(2'd1, VEC[i][3] ? 32'h400 : 32'h0);
      wr(2'd2, 32'h10000);
      chk(div_sel == es, VEC[i][3] ? "R4 decode" : (VEC[i][9:7] == 3'd7 ? "R6 reserved" : "R5 decode"),
          32'(div_sel), 32'(es));
      wait_tick(n);
      chk(n == (1 << es), "R8 first tick delay", n, 1 << es);
      chk(dec_value == 32'hFFFF_FFFF && dec_wrap, "R10 wrap from zero", dec_value, 32'hFFFF_FFFF);
      wait_tick(n);
      chk(n == (1 << es), "R7 tick period", n, 1 << es);
    end

    // R6 reserved code keeps a non-default ratio
    do_reset();
    wr(2'd0, 32'h10);
    wr(2'd2, 32'h10000);
    chk(div_sel == 3'd2, "R5 coarse code 2", 32'(div_sel), 2);
    wr(2'd0, 32'h38);
    wr(2'd2, 32'h0);
    chk(div_sel == 3'd2, "R6 reserved keeps ratio", 32'(div_sel), 2);

    // R9 R10 R11 at divide by 1
    do_reset();
    wr(2'd2, 32'h10000);
    @(negedge clk);
    chk(dec_wrap == 1'b1, "R10 flag set", 32'(dec_wrap), 1);
    @(negedge clk);
    chk(dec_wrap == 1'b1, "R10 flag sticky", 32'(dec_wrap), 1);
    wr(2'd3, 32'd5);
    chk(dec_value == 32'd5 && !dec_wrap, "R11 load over tick", dec_value, 5);
    @(negedge clk);
    chk(dec_value == 32'd4, "R9 step", dec_value, 4);
    wr(2'd3, 32'd1);
    chk(dec_value == 32'd1, "R11 load", dec_value, 1);
    @(negedge clk);
    chk(dec_value == 32'd0 && !dec_wrap, "R10 at zero no flag", dec_value, 0);
    @(negedge clk);
    chk(dec_value == 32'hFFFF_FFFF && dec_wrap, "R10 wrap", dec_value, 32'hFFFF_FFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog expired act=%0d exp=%0d", 100000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule